// File: doc/BRIEF.md
# Cascaded FIFO Depth-Expansion Controller

This block joins several identical FIFO slices into one deeper FIFO. Each slice has a small local memory of `DEPTH` words of 9 bits. No shared address decoder picks the slice. A write token and a separate read token travel around a ring of slices instead, and only the slice that holds a token takes part on that side. When the active writing slice fills its last physical location, it raises a one-cycle write-hop pulse and the write token moves to the next slice. Reads work the same way with a read-hop pulse. The last slice hands its tokens back to the first.

The controller takes two configuration inputs while master reset is held. The first is the operating mode, chained or standalone. The second is a one-hot choice of the slice that loads first. In chained mode the ring forms a FIFO of `NSLICE*DEPTH` words. The composite full flag is the AND of the per-slice full flags, and the composite empty flag is the AND of the per-slice empty flags. In standalone mode the tokens never leave the first-load slice, so capacity is `DEPTH` words. The block has no half-full indication and no replay function. Read data is show-ahead. Every slice drives a lane of an OR-combined bus, and all lanes are zero except the lane of the read-token slice while that slice holds data.

Top module: `cascade_fifo`

## Requirements
- R1: While and just after reset, `empty_o`=1, `full_o`=0, `rd_data_o`=0, and both `wr_tok_o` and `rd_tok_o` equal the one-hot `first_load_i` sampled during reset (bit k is slice k).
- R2: In chained mode, words come out in the order they were accepted, across every slice boundary and every wrap of the ring. Capacity is `NSLICE*DEPTH`.
- R3: In chained mode, a write accepted into the last location (index `DEPTH-1`) of the write-token slice k sets `wr_hop_o[k]` in that same cycle, and only for that cycle. From the next cycle the write token is at slice (k+1) mod `NSLICE`.
- R4: In chained mode, a read accepted from the last location of the read-token slice k sets `rd_hop_o[k]` in that cycle. From the next cycle the read token is at slice (k+1) mod `NSLICE`.
- R5: Out of reset, `wr_tok_o` and `rd_tok_o` each have exactly one bit set.
- R6: `full_o` is 1 exactly when the stored count equals capacity. A write while `full_o`=1 is ignored, even when a read happens in the same cycle: nothing is stored and no hop occurs.
- R7: `empty_o` is 1 exactly when no word is stored. A read while `empty_o`=1 is ignored, even when a write happens in the same cycle: the head does not move and no hop occurs.
- R8: `rd_data_o` shows the oldest stored word whenever `empty_o`=0, and zero when `empty_o`=1. A read is accepted when `rd_en_i`=1 and `empty_o`=0 at a rising clock edge.
- R9: The mode (`chain_mode_i`=1 chained, 0 standalone) and the first-load slice are sampled only while `rst` is 1, and changes after reset have no effect. In standalone mode both tokens stay on the first-load slice, capacity is `DEPTH`, and both hop outputs stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high; configuration sampled while high |
| chain_mode_i | input | 1 | 1 selects chained ring, 0 standalone (sampled in reset) |
| first_load_i | input | NSLICE | One-hot first-load slice (sampled in reset) |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 9 | Write data |
| rd_en_i | input | 1 | Read request (pops the shown word) |
| rd_data_o | output | 9 | OR-combined read bus, oldest word or zero |
| full_o | output | 1 | Composite full |
| empty_o | output | 1 | Composite empty |
| wr_tok_o | output | NSLICE | One-hot write-token holder |
| rd_tok_o | output | NSLICE | One-hot read-token holder |
| wr_hop_o | output | NSLICE | Write-hop pulse per slice |
| rd_hop_o | output | NSLICE | Read-hop pulse per slice |

## Verification
The bench builds the block with three slices of four words each. This makes a 12-word ring, small enough that alternating fill and drain phases cross every slice boundary and wrap the ring many times within a few hundred cycles. It sweeps all three first-load positions in both modes. It flips the configuration inputs after reset to show that they are ignored. The fill and drain phases push the FIFO hard into full and empty, so that writes at full and reads at empty are applied with and without a simultaneous operation on the other side.

// File: rtl/cascade_fifo.sv
module cascade_fifo #(
  parameter int NSLICE = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chain_mode_i,
  input  logic [NSLICE-1:0] first_load_i,
  input  logic              wr_en_i,
  input  logic [8:0]        wr_data_i,
  input  logic              rd_en_i,
  output logic [8:0]        rd_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [NSLICE-1:0] wr_tok_o,
  output logic [NSLICE-1:0] rd_tok_o,
  output logic [NSLICE-1:0] wr_hop_o,
  output logic [NSLICE-1:0] rd_hop_o
);
  localparam int W  = 9;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic              chain_q;
  logic [NSLICE-1:0] lead_q, wr_tok, rd_tok;
  logic [NSLICE-1:0] sfull, sempty, wlast, rlast;
  logic [W-1:0]      lane [NSLICE];
  logic              wr_ok, rd_ok;

  assign full_o   = chain_q ? &sfull : |(sfull & lead_q);
  assign empty_o  = &sempty;
  assign wr_ok    = wr_en_i & ~full_o;
  assign rd_ok    = rd_en_i & ~empty_o;
  assign wr_tok_o = wr_tok;
  assign rd_tok_o = rd_tok;
  assign wr_hop_o = chain_q ? wlast : '0;
  assign rd_hop_o = chain_q ? rlast : '0;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    logic [W-1:0]  ram [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          wsel, rsel;

    assign wsel      = wr_tok[i] & wr_ok;
    assign rsel      = rd_tok[i] & rd_ok;
    assign wlast[i]  = wsel & (wp == AW'(DEPTH - 1));
    assign rlast[i]  = rsel & (rp == AW'(DEPTH - 1));
    assign sfull[i]  = (cnt == CW'(DEPTH));
    assign sempty[i] = (cnt == '0);
    assign lane[i]   = (rd_tok[i] & ~sempty[i]) ? ram[rp] : '0;

    always_ff @(posedge clk)
      if (wsel) ram[wp] <= wr_data_i;

    always_ff @(posedge clk) begin
      if (rst) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (wsel) wp <= wlast[i] ? '0 : wp + 1'b1;
        if (rsel) rp <= rlast[i] ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(wsel) - CW'(rsel);
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NSLICE; k++) rd_data_o = rd_data_o | lane[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= chain_mode_i;
      lead_q  <= first_load_i;
      wr_tok  <= first_load_i;
      rd_tok  <= first_load_i;
    end else if (chain_q) begin
      wr_tok <= (wr_tok & ~wlast) | {wlast[NSLICE-2:0], wlast[NSLICE-1]};
      rd_tok <= (rd_tok & ~rlast) | {rlast[NSLICE-2:0], rlast[NSLICE-1]};
    end
  end

  AST_WTOK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_tok_o) == 1); // R5
  AST_RTOK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_tok_o) == 1); // R5
  AST_WHOP_MOVES: assert property (@(posedge clk) disable iff (rst)
    (|wr_hop_o) |=> (wr_tok_o != $past(wr_tok_o))); // R3
  AST_RHOP_MOVES: assert property (@(posedge clk) disable iff (rst)
    (|rd_hop_o) |=> (rd_tok_o != $past(rd_tok_o))); // R4
  AST_HOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hop_o) && $onehot0(rd_hop_o)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full_o && !rd_en_i) |=> full_o); // R6
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    empty_o |-> (rd_hop_o == '0 && rd_data_o == '0)); // R7
  AST_SOLO_STAY: assert property (@(posedge clk) disable iff (rst)
    !chain_q |-> (wr_tok_o == lead_q && rd_tok_o == lead_q)); // R9
endmodule

// File: tb/tb_cascade_fifo.sv
module tb_cascade_fifo;
  localparam int N = 3;
  localparam int D = 4;
  localparam int MAXQ = N * D;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         chain_mode_i = 1'b1;
  logic [N-1:0] first_load_i = 3'b001;
  logic         wr_en_i = 1'b0;
  logic [8:0]   wr_data_i = '0;
  logic         rd_en_i = 1'b0;
  logic [8:0]   rd_data_o;
  logic         full_o, empty_o;
  logic [N-1:0] wr_tok_o, rd_tok_o, wr_hop_o, rd_hop_o;

  int vec = 0;
  int bad = 0;

  cascade_fifo #(.NSLICE(N), .DEPTH(D)) dut (
    .clk(clk), .rst(rst), .chain_mode_i(chain_mode_i), .first_load_i(first_load_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .full_o(full_o), .empty_o(empty_o), .wr_tok_o(wr_tok_o), .rd_tok_o(rd_tok_o),
    .wr_hop_o(wr_hop_o), .rd_hop_o(rd_hop_o));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int q [MAXQ];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic run_case(input bit chain, input int lead, input int ncyc);
    int head = 0, size = 0, wacc = 0, racc = 0, seq = 0;
    int cap = chain ? MAXQ : D;
    rst = 1'b1;
    chain_mode_i = chain;
    first_load_i = N'(1 << lead);
    wr_en_i = 1'b0;
    rd_en_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #9;
    chk("R1 empty", empty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 data", rd_data_o, 0);
    chk("R1 wtok", wr_tok_o, 1 << lead);
    chk("R1 rtok", rd_tok_o, 1 << lead);
    for (int c = 0; c < ncyc; c++) begin
      int wslot, rslot, exp_wh, exp_rh, r;
      bit fill, wok, rok;
      @(negedge clk);
      chain_mode_i = ~chain;                         // R9: ignored after reset
      first_load_i = N'(1 << ((lead + 1 + c) % N));  // R9: ignored after reset
      lfsr = lfsr[0] ? ((lfsr >> 1) ^ 32'hB4BC_D35C) : (lfsr >> 1);
      r = int'(lfsr[7:0]);
      fill = ((c / 40) % 2) == 0;
      wr_en_i = fill ? ((r % 4) != 0) : ((r % 4) == 0);
      rd_en_i = fill ? (((r >> 2) % 4) == 0) : (((r >> 2) % 4) != 0);
      wr_data_i = 9'((seq * 37 + lead * 5 + (chain ? 0 : 200)) & 511);
      #9;
      wok = wr_en_i && (size < cap);
      rok = rd_en_i && (size > 0);
      wslot = chain ? (lead + wacc / D) % N : lead;
      rslot = chain ? (lead + racc / D) % N : lead;
      exp_wh = (chain && wok && (wacc % D) == D - 1) ? (1 << wslot) : 0;
      exp_rh = (chain && rok && (racc % D) == D - 1) ? (1 << rslot) : 0;
      chk("R6 full", full_o, int'(size == cap));
      chk("R7 empty", empty_o, int'(size == 0));
      chk("R8/R2 data", rd_data_o, size > 0 ? q[head] : 0);
      chk("R5/R9 wtok", wr_tok_o, 1 << wslot);
      chk("R5/R9 rtok", rd_tok_o, 1 << rslot);
      chk("R3 whop", wr_hop_o, exp_wh);
      chk("R4 rhop", rd_hop_o, exp_rh);
      @(posedge clk);
      if (rok) begin
        head = (head + 1) % MAXQ;
        size--;
        racc++;
      end
      if (wok) begin
        q[(head + size) % MAXQ] = int'(wr_data_i);
        size++;
        wacc++;
        seq++;
      end
    end
  endtask

  initial begin
    for (int m = 1; m >= 0; m--)
      for (int l = 0; l < N; l++)
        run_case(m[0], l, 240);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    vec++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule